// File: doc/BRIEF.md
# Static Memory Chip-Select Timing Controller

This block runs single read and write accesses to external asynchronous memories, such as SRAM or flash, on eight chip selects. Each chip select has its own configuration word. The word sets the strobe length in wait states, turns wait states on or off, picks standard or early read timing, gives the bus width and byte-lane scheme, and sets a data-float time. After an access, the float time keeps the bus reserved before a different chip select may use it.

All timing is counted on `clk`, which runs at twice the memory bus rate. One tick of `clk` is half a bus cycle, so half-cycle strobe widths come out exact. A requester holds `reqValid` with the chip select, direction, address, data and byte enables. The request is taken on the first rising edge at which `reqReady` is high. The strobe window opens on the next tick. When the window closes, `done` pulses for one tick. For a read, `rdData` then holds the data sampled on the last strobe tick. All memory-side strobes are active low.

Top module: `smc_cs_timing`

## Requirements
- R1: Eight configuration words are written through `cfgWe`/`cfgSel`/`cfgWdata` and read back on `cfgRdata` for `cfgSel`. The bit layout is: waits [6:0], wait enable [7], float time [11:8], 16-bit bus [12], single 16-bit device [13], early read [14]. When the wait enable bit is 0, the waits field reads back as 0, whatever value is stored. All words reset to 0.
- R2: A standard read holds `memRdN` low for 2X+3 ticks with wait states enabled, and for 1 tick with them disabled. X is the waits field.
- R3: An early read holds `memRdN` low for 2X+4 ticks with wait states enabled, and for 2 ticks with them disabled.
- R4: A write strobe lasts 2X+2 ticks with wait states enabled, and 1 tick with them disabled.
- R5: The strobe window opens on the tick after acceptance. During the window, only the addressed bit of `memCsN` is low, `memAddr` shows the request address, and for writes `memDataOe` is high with `memWdata` showing the write data. Outside the window, all chip selects are high and `memDataOe` is low.
- R6: `done` is high for exactly the one tick after the last strobe tick. For a read, `rdData` equals `memRdata` as sampled on that last strobe tick.
- R7: After `done`, a request to a different chip select sees `reqReady` low until 2T ticks after the `done` tick. T is the float-time field of the chip select just used.
- R8: A request to the chip select last used is not subject to the float lockout. `reqReady` is high on the `done` tick itself.
- R9: `reqReady` is low during the strobe window. A held request starts no access until `reqReady` is high.
- R10: With the 16-bit bus bit at 0 (8-bit bus), writes use `memWrN[0]` only, `memWrN[1]` stays high, and `memBlsN` stays high.
- R11: With a 16-bit bus and the single-device bit at 0 (two 8-bit devices), `memWrN[i]` strobes only when `reqBe[i]` is 1, and `memBlsN` stays high.
- R12: With a 16-bit bus and the single-device bit at 1, writes strobe `memWrN[0]` only. `memBlsN[i]` is low through the window, for reads and writes, when `reqBe[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rstN | input | 1 | Active-low reset |
| cfgWe | input | 1 | Configuration write enable |
| cfgSel | input | 3 | Configuration word select |
| cfgWdata | input | 15 | Configuration word to write |
| cfgRdata | output | 15 | Selected configuration word, waits masked |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Request is accepted at this edge |
| reqCs | input | 3 | Target chip select |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables |
| done | output | 1 | One-tick completion pulse |
| rdData | output | 16 | Captured read data |
| memCsN | output | 8 | Chip selects, active low |
| memAddr | output | 16 | Memory address |
| memWdata | output | 16 | Memory write data |
| memDataOe | output | 1 | Write data drive enable |
| memRdN | output | 1 | Read strobe, active low |
| memWrN | output | 2 | Per-byte write strobes, active low |
| memBlsN | output | 2 | Byte-lane selects, active low |
| memRdata | input | 16 | Memory read data |

## Verification
`reqReady` is combinational, so it is due in the same tick as the request and its lockout state. The strobe window, chip select, address and lanes follow acceptance by one tick. `done` and `rdData` follow the last strobe tick by one tick, and a different chip select is released exactly 2T ticks after `done`. A behavioural model in the bench updates on each rising edge from the bench's own copy of the configuration. Every output is compared with that model at each falling edge, after all register updates have settled.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int WAIT_W  = 7;
  localparam int FLOAT_W = 4;
  localparam int CFG_W   = WAIT_W + FLOAT_W + 4;
  localparam int CNT_W   = WAIT_W + 2;
  localparam int FCNT_W  = FLOAT_W + 1;

  typedef struct packed {
    logic               earlyRd;
    logic               singleDev;
    logic               bus16;
    logic [FLOAT_W-1:0] floatT;
    logic               waitEn;
    logic [WAIT_W-1:0]  waits;
  } csCfg_t;

  typedef struct packed {
    logic load;
    logic active;
    logic capture;
  } ctlStrb_t;
endpackage

// File: rtl/smc_cfg_bank.sv
module smc_cfg_bank
  import smc_pkg::*;
#(
  parameter int NCS = 8,
  localparam int CSW = $clog2(NCS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CSW-1:0]       cfgSel,
  input  csCfg_t               cfgWdata,
  output csCfg_t               cfgRdata,
  output csCfg_t [NCS-1:0]     cfgAll
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAll <= '0;
    end else begin
      for (int i = 0; i < NCS; i++) begin
        if (cfgWe && cfgSel == CSW'(i)) cfgAll[i] <= cfgWdata;
      end
    end
  end

  always_comb begin
    cfgRdata = cfgAll[cfgSel];
    if (!cfgRdata.waitEn) cfgRdata.waits = '0;
  end
endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
#(
  parameter int NCS = 8,
  localparam int CSW = $clog2(NCS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CSW-1:0]     reqCs,
  input  logic               reqWrite,
  input  logic [WAIT_W-1:0]  reqWaits,
  input  logic               reqWaitEn,
  input  logic               reqEarly,
  input  logic [FLOAT_W-1:0] reqFloat,
  output logic               reqReady,
  output logic               done,
  output ctlStrb_t           strb
);
  logic               busy;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   len;
  logic [CNT_W-1:0]   twoX;
  logic [FCNT_W-1:0]  floatCnt;
  logic [FLOAT_W-1:0] tdfCur;
  logic [CSW-1:0]     curCs;
  logic [CSW-1:0]     lastCs;
  logic               locked;
  logic               accept;
  logic               lastTick;

  assign twoX = {1'b0, reqWaits, 1'b0};

  always_comb begin
    if (reqWrite)     len = reqWaitEn ? twoX + CNT_W'(2) : CNT_W'(1);
    else if (reqEarly) len = reqWaitEn ? twoX + CNT_W'(4) : CNT_W'(2);
    else               len = reqWaitEn ? twoX + CNT_W'(3) : CNT_W'(1);
  end

  assign locked   = (floatCnt != '0) && (reqCs != lastCs);
  assign reqReady = !busy && !locked;
  assign accept   = reqValid && reqReady;
  assign lastTick = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      floatCnt <= '0;
      tdfCur   <= '0;
      curCs    <= '0;
      lastCs   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (floatCnt != '0) floatCnt <= floatCnt - FCNT_W'(1);
      if (busy) begin
        if (lastTick) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          floatCnt <= {tdfCur, 1'b0};
          lastCs   <= curCs;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end else if (accept) begin
        busy   <= 1'b1;
        cnt    <= len;
        curCs  <= reqCs;
        tdfCur <= reqFloat;
      end
    end
  end

  assign strb.load    = accept;
  assign strb.active  = busy;
  assign strb.capture = lastTick;
endmodule

// File: rtl/smc_datapath.sv
module smc_datapath
  import smc_pkg::*;
#(
  parameter int NCS = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  localparam int CSW   = $clog2(NCS),
  localparam int NLANE = DW / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [CSW-1:0]    reqCs,
  input  logic              reqWrite,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DW-1:0]     reqWdata,
  input  logic [NLANE-1:0]  reqBe,
  input  logic              reqBus16,
  input  logic              reqSingle,
  input  logic [DW-1:0]     memRdata,
  output logic [DW-1:0]     rdData,
  output logic [NCS-1:0]    memCsN,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata,
  output logic              memDataOe,
  output logic              memRdN,
  output logic [NLANE-1:0]  memWrN,
  output logic [NLANE-1:0]  memBlsN
);
  logic [CSW-1:0]   csQ;
  logic             wrQ;
  logic [NLANE-1:0] beQ;
  logic             bus16Q;
  logic             singleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ      <= '0;
      wrQ      <= 1'b0;
      beQ      <= '0;
      bus16Q   <= 1'b0;
      singleQ  <= 1'b0;
      memAddr  <= '0;
      memWdata <= '0;
      rdData   <= '0;
    end else begin
      if (strb.load) begin
        csQ      <= reqCs;
        wrQ      <= reqWrite;
        beQ      <= reqBe;
        bus16Q   <= reqBus16;
        singleQ  <= reqSingle;
        memAddr  <= reqAddr;
        memWdata <= reqWdata;
      end
      if (strb.capture && !wrQ) rdData <= memRdata;
    end
  end

  assign memDataOe = strb.active && wrQ;
  assign memRdN    = !(strb.active && !wrQ);

  for (genvar c = 0; c < NCS; c++) begin : g_cs
    assign memCsN[c] = !(strb.active && csQ == CSW'(c));
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic wrLaneOn;
    always_comb begin
      if (!bus16Q)      wrLaneOn = (l == 0);
      else if (singleQ) wrLaneOn = (l == 0);
      else              wrLaneOn = beQ[l];
    end
    assign memWrN[l]  = !(strb.active && wrQ && wrLaneOn);
    assign memBlsN[l] = !(strb.active && bus16Q && singleQ && beQ[l]);
  end
endmodule

// File: rtl/smc_cs_timing.sv
module smc_cs_timing
  import smc_pkg::*;
#(
  parameter int NCS = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  localparam int CSW   = $clog2(NCS),
  localparam int NLANE = DW / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CSW-1:0]   cfgSel,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [CSW-1:0]   reqCs,
  input  logic             reqWrite,
  input  logic [AW-1:0]    reqAddr,
  input  logic [DW-1:0]    reqWdata,
  input  logic [NLANE-1:0] reqBe,
  output logic             done,
  output logic [DW-1:0]    rdData,
  output logic [NCS-1:0]   memCsN,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  output logic             memDataOe,
  output logic             memRdN,
  output logic [NLANE-1:0] memWrN,
  output logic [NLANE-1:0] memBlsN,
  input  logic [DW-1:0]    memRdata
);
  csCfg_t           cfgRd;
  csCfg_t [NCS-1:0] cfgAll;
  csCfg_t           reqCfg;
  ctlStrb_t         strb;

  assign cfgRdata = cfgRd;
  assign reqCfg   = cfgAll[reqCs];

  smc_cfg_bank #(.NCS(NCS)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(csCfg_t'(cfgWdata)), .cfgRdata(cfgRd), .cfgAll(cfgAll)
  );

  smc_ctrl #(.NCS(NCS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCs(reqCs),
    .reqWrite(reqWrite), .reqWaits(reqCfg.waits), .reqWaitEn(reqCfg.waitEn),
    .reqEarly(reqCfg.earlyRd), .reqFloat(reqCfg.floatT),
    .reqReady(reqReady), .done(done), .strb(strb)
  );

  smc_datapath #(.NCS(NCS), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqCs(reqCs), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .reqBus16(reqCfg.bus16), .reqSingle(reqCfg.singleDev),
    .memRdata(memRdata), .rdData(rdData), .memCsN(memCsN), .memAddr(memAddr),
    .memWdata(memWdata), .memDataOe(memDataOe), .memRdN(memRdN),
    .memWrN(memWrN), .memBlsN(memBlsN)
  );
endmodule

// File: rtl/smc_cs_timing_chk.sv
module smc_cs_timing_chk #(
  parameter int NCS   = 8,
  parameter int NLANE = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [NCS-1:0]   memCsN,
  input logic             memRdN,
  input logic [NLANE-1:0] memWrN,
  input logic             memDataOe,
  input logic             done,
  input logic             reqReady
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN)); // R5
  AST_RD_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    !memRdN |-> (memCsN != '1)); // R5
  AST_WR_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    (memWrN != '1) |-> memDataOe); // R5
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!memRdN && memDataOe)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(memCsN) != '1) && (memCsN == '1)); // R6
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (memCsN != '1) |-> !reqReady); // R9
endmodule

bind smc_cs_timing smc_cs_timing_chk #(.NCS(NCS), .NLANE(NLANE)) u_chk (
  .clk(clk), .rstN(rstN), .memCsN(memCsN), .memRdN(memRdN), .memWrN(memWrN),
  .memDataOe(memDataOe), .done(done), .reqReady(reqReady)
);

// File: tb/sim_smc_cs_timing.sv
module sim_smc_cs_timing;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [14:0] cfgWdata = '0;
  logic [14:0] cfgRdata;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqCs = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic        done;
  logic [15:0] rdData;
  logic [7:0]  memCsN;
  logic [15:0] memAddr;
  logic [15:0] memWdata;
  logic        memDataOe;
  logic        memRdN;
  logic [1:0]  memWrN;
  logic [1:0]  memBlsN;
  logic [15:0] memRdata;

  assign memRdata = memAddr ^ 16'h5A3C;

  smc_cs_timing u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int ticks  = 0;
  bit running = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bench copy of configuration
  logic [14:0] cfgMem [8];

  function automatic logic [14:0] cw(input bit early, input bit single, input bit b16,
                                     input int tdf, input bit en, input int waits);
    return {early, single, b16, 4'(tdf), en, 7'(waits)};
  endfunction

  // behavioural model state
  bit          mBusy, mDone, mWr, mEarly, mB16, mSingle;
  int          mLeft, mFloat, mCs, mLast;
  logic [15:0] mAddr, mWdata, mRdExp;
  logic [1:0]  mBe;

  always @(posedge clk) begin
    ticks++;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mFloat = 0; mLast = 0; mCs = 0; mLeft = 0; mWr = 0;
      mRdExp = '0;
    end else begin
      bit rdy;
      rdy = !mBusy && (mFloat == 0 || int'(reqCs) == mLast);
      mDone = 0;
      if (mFloat > 0) mFloat--;
      if (mBusy) begin
        if (mLeft == 1) begin
          mBusy = 0; mDone = 1; mLast = mCs;
          mFloat = 2 * int'(cfgMem[mCs][11:8]);
          if (!mWr) mRdExp = mAddr ^ 16'h5A3C;
        end else mLeft--;
      end else if (reqValid && rdy) begin
        logic [14:0] c;
        int x;
        c = cfgMem[reqCs];
        x = int'(c[6:0]);
        mBusy = 1; mCs = int'(reqCs); mWr = reqWrite; mAddr = reqAddr;
        mWdata = reqWdata; mBe = reqBe; mEarly = c[14]; mB16 = c[12]; mSingle = c[13];
        if (reqWrite)  mLeft = c[7] ? 2*x + 2 : 1;
        else if (c[14]) mLeft = c[7] ? 2*x + 4 : 2;
        else            mLeft = c[7] ? 2*x + 3 : 1;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      logic [7:0] expCs;
      logic [1:0] expWr, expBls;
      bit expRdy;
      string laneTag;
      expCs = mBusy ? ~(8'b1 << mCs) : 8'hFF;
      chk(memCsN == expCs, "R5 chip select", memCsN, expCs);
      chk(memRdN == !(mBusy && !mWr), mEarly ? "R3 early read strobe" : "R2 standard read strobe",
          memRdN, !(mBusy && !mWr));
      expWr = 2'b11; expBls = 2'b11;
      if (mBusy && mWr) begin
        if (!mB16) expWr = 2'b10;
        else if (mSingle) expWr = 2'b10;
        else expWr = ~mBe;
      end
      if (mBusy && mB16 && mSingle) expBls = ~mBe;
      laneTag = !mB16 ? "R4 R10 write strobe" : (mSingle ? "R4 R12 write strobe" : "R4 R11 write strobe");
      chk(memWrN == expWr, laneTag, memWrN, expWr);
      chk(memBlsN == expBls, mSingle ? "R12 byte lanes" : "R10 R11 byte lanes", memBlsN, expBls);
      chk(memDataOe == (mBusy && mWr), "R5 data enable", memDataOe, mBusy && mWr);
      if (mBusy) chk(memAddr == mAddr, "R5 address", memAddr, mAddr);
      if (mBusy && mWr) chk(memWdata == mWdata, "R5 write data", memWdata, mWdata);
      chk(done == mDone, "R6 done pulse", done, mDone);
      if (mDone && !mWr) chk(rdData == mRdExp, "R6 read data", rdData, mRdExp);
      expRdy = !mBusy && (mFloat == 0 || int'(reqCs) == mLast);
      chk(reqReady == expRdy,
          mBusy ? "R9 ready while busy" : ((mFloat != 0 && int'(reqCs) != mLast) ? "R7 float lockout" : "R8 same select"),
          reqReady, expRdy);
    end
  end

  task automatic writeCfg(input int sel, input logic [14:0] w);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgSel = 3'(sel); cfgWdata = w;
    cfgMem[sel] = w;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic checkCfg(input int sel);
    logic [14:0] e;
    @(negedge clk);
    cfgSel = 3'(sel);
    #1;
    e = cfgMem[sel];
    if (!e[7]) e[6:0] = '0;
    chk(cfgRdata == e, "R1 config readback", cfgRdata, e);
  endtask

  task automatic issue(input int cs, input bit wr, input logic [15:0] a,
                       input logic [15:0] d, input logic [1:0] be);
    #1;
    reqValid = 1'b1; reqCs = 3'(cs); reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    forever begin
      @(negedge clk);
      if (reqReady) break;
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    forever begin
      @(negedge clk);
      if (!mBusy) break;
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) cfgMem[i] = '0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    running = 1;
    // reset state: all words zero (R1)
    checkCfg(0);
    checkCfg(5);
    writeCfg(0, cw(0, 0, 0, 2, 1, 3));
    writeCfg(1, cw(1, 0, 1, 1, 0, 5));
    writeCfg(2, cw(1, 1, 1, 0, 1, 0));
    writeCfg(3, cw(0, 1, 1, 3, 1, 2));
    writeCfg(5, cw(0, 0, 1, 15, 0, 127));
    writeCfg(6, cw(1, 0, 0, 1, 1, 1));
    writeCfg(7, cw(0, 0, 0, 15, 1, 127));
    for (int i = 0; i < 8; i++) checkCfg(i);

    issue(0, 0, 16'h1000, 16'h0, 2'b11);   // R2 standard read with waits
    issue(0, 1, 16'h1002, 16'hBEEF, 2'b11); // R8 same select, R4 R10
    issue(1, 0, 16'h2000, 16'h0, 2'b11);   // R7 lockout, R3 early no waits
    issue(1, 1, 16'h2004, 16'hA1B2, 2'b10); // R11 upper byte only
    issue(1, 1, 16'h2006, 16'hC3D4, 2'b01); // R11 lower byte only
    issue(2, 1, 16'h3000, 16'h5566, 2'b01); // R12 single device write
    issue(2, 0, 16'h3002, 16'h0, 2'b11);   // R3 early with zero waits
    issue(3, 0, 16'h4000, 16'h0, 2'b10);   // R12 lanes on read
    issue(3, 1, 16'h4002, 16'h7788, 2'b11);
    issue(0, 0, 16'h1004, 16'h0, 2'b11);   // R7 lockout after T=3
    issue(4, 0, 16'h5000, 16'h0, 2'b11);   // R2 no waits, half cycle
    issue(4, 1, 16'h5002, 16'h99AA, 2'b11); // R4 no waits
    issue(5, 1, 16'h6000, 16'h1234, 2'b00); // R11 no byte enabled
    issue(6, 0, 16'h7000, 16'h0, 2'b11);   // R3 early with waits, R7 T=15
    issue(7, 0, 16'h8000, 16'h0, 2'b11);   // R2 maximum waits
    issue(7, 1, 16'h8002, 16'hFEDC, 2'b11); // R4 maximum waits
    issue(0, 1, 16'h1006, 16'h4321, 2'b11); // R7 held for 30 ticks
    waitIdle();
    repeat (40) @(posedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (ticks >= WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", ticks, WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule